// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the controller side of a byte-wide host mailbox with two port offsets. Offset 4 is the command/status port: writes to it carry a command byte and reads from it return a status byte. Offset 0 is the data port, which carries address and data bytes in both directions. The host paces every byte with two flags in the status byte. Input-buffer-full means a byte is waiting for the controller. Output-buffer-full means a byte is ready for the host. The host waits for the first to clear before each write and for the second to set before each read.

Accepted bytes are decoded into accesses to a 256-byte register space that lives in the rest of the controller. The block reaches it through a simple strobe port with a combinational read return. A read needs a read command and one address byte. A write needs a write command, an address byte and a data byte. The burst enable, burst disable and query commands are accepted, but they only affect the status bits and the data port. The interrupt control offset and event sources are not implemented.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00 and the sequencer is idle.
- R2: The status byte has output-buffer-full at bit 0, input-buffer-full at bit 1, the command flag at bit 3 and the burst flag at bit 4. The SCI-pending bit 5, the SMI-pending bit 6 and all other bits read 0.
- R3: A host write to offset 0 or 4 while input-buffer-full is clear sets input-buffer-full for exactly CONSUME_CYCLES cycles. A host write made while input-buffer-full is set is dropped and has no effect.
- R4: The command flag (status bit 3) is 1 when the last accepted byte came through offset 4 and 0 when it came through offset 0.
- R5: Command 0x81 followed by an address byte and a data byte on offset 0 produces one register-space write of that data to that address.
- R6: Command 0x80 followed by an address byte on offset 0 loads the register value at that address into the data port and sets output-buffer-full.
- R7: A host read of offset 0 clears output-buffer-full. A read of offset 4 changes nothing.
- R8: Command 0x82 sets the burst flag and command 0x83 clears it.
- R9: Command 0x84 loads 0x00 into the data port and sets output-buffer-full.
- R10: A command byte accepted in the middle of a read or write sequence abandons that sequence without any register access, and decoding starts again from the new command.
- R11: A data byte accepted while no sequence is pending, and any command byte other than 0x80 to 0x84, cause no register access and leave output-buffer-full clear.
- R12: Host writes to offsets other than 0 and 4 are ignored, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_ofs | input | 4 | Host port offset (0 data, 4 command/status) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational on host_ofs |
| reg_wr | output | 1 | Register-space write strobe |
| reg_rd | output | 1 | Register-space read strobe |
| reg_addr | output | 8 | Register-space address |
| reg_wdata | output | 8 | Register-space write data |
| reg_rdata | input | 8 | Register-space read data, same cycle as reg_rd |

## Verification
The bench builds the block with CONSUME_CYCLES set to 3 instead of 8. This keeps each handshake short, so many complete command sequences fit in the run. It also lets the bench count the exact high time of input-buffer-full. The short window also leaves room to place a second host write inside the busy period, which tests the dropped-write rule. It also allows a new command to be placed between the address and data bytes of a write, which tests the abort rule.

// File: rtl/ec_host_port.sv
module ec_host_port #(
  parameter int CONSUME_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [3:0] host_ofs,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);

  localparam logic [3:0] OFS_DATA = 4'd0;
  localparam logic [3:0] OFS_CMD  = 4'd4;
  localparam int CW = $clog2(CONSUME_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONSUME_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_RADDR, S_WADDR, S_WDATA} seq_t;

  seq_t          st;
  logic          ibf, obf, cmd_flag, burst;
  logic [7:0]    in_q, out_q, addr_q;
  logic [CW-1:0] cnt;

  wire hit       = (host_ofs == OFS_DATA) || (host_ofs == OFS_CMD);
  wire accept    = host_wr && hit && !ibf;
  wire consume   = ibf && (cnt == LAST);
  wire take_data = consume && !cmd_flag;
  wire obf_clr   = host_rd && (host_ofs == OFS_DATA);

  assign reg_rd    = take_data && (st == S_RADDR);
  assign reg_wr    = take_data && (st == S_WDATA);
  assign reg_addr  = (st == S_RADDR) ? in_q : addr_q;
  assign reg_wdata = in_q;

  wire [7:0] status = {3'b000, burst, cmd_flag, 1'b0, ibf, obf};

  assign host_rdata = (host_ofs == OFS_DATA) ? out_q :
                      (host_ofs == OFS_CMD)  ? status : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ibf <= 1'b0;
      obf <= 1'b0;
      cmd_flag <= 1'b0;
      burst <= 1'b0;
      in_q <= 8'h00;
      out_q <= 8'h00;
      addr_q <= 8'h00;
      cnt <= '0;
    end else begin
      if (accept) begin
        ibf <= 1'b1;
        in_q <= host_wdata;
        cmd_flag <= (host_ofs == OFS_CMD);
        cnt <= '0;
      end else if (ibf) begin
        cnt <= cnt + 1'b1;
        if (consume) ibf <= 1'b0;
      end

      if (obf_clr) obf <= 1'b0;

      if (consume) begin
        if (cmd_flag) begin
          st <= S_IDLE;
          case (in_q)
            8'h80: st <= S_RADDR;
            8'h81: st <= S_WADDR;
            8'h82: burst <= 1'b1;
            8'h83: burst <= 1'b0;
            8'h84: begin out_q <= 8'h00; obf <= 1'b1; end
            default: ;
          endcase
        end else begin
          case (st)
            S_RADDR: begin out_q <= reg_rdata; obf <= 1'b1; st <= S_IDLE; end
            S_WADDR: begin addr_q <= in_q; st <= S_WDATA; end
            S_WDATA: st <= S_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ibf);
  assert_ibf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && !consume) |=> ibf);
  assert_obf_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> $past(consume));
  assert_obf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (obf_clr && !consume) |=> !obf);
  assert_access_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  assert_write_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (st == S_IDLE));

endmodule

// File: tb/tb_ec_host_port.sv
`timescale 1ns/1ps
module tb_ec_host_port;
  localparam int N = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_ofs = 4'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, reg_addr, reg_wdata, reg_rdata;
  logic reg_wr, reg_rd;
  logic [7:0] mem [256];
  int checks = 0, fails = 0, wr_count = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ec_host_port #(.CONSUME_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_count++; end

  // {is_write, address, data}: writes load values, reads expect them
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 8'h10, 8'hA5}, {1'b1, 8'h30, 8'h11}, {1'b1, 8'h40, 8'h5C},
    {1'b1, 8'hFF, 8'h01}, {1'b1, 8'h00, 8'hEE},
    {1'b0, 8'h10, 8'hA5}, {1'b0, 8'h30, 8'h11}, {1'b0, 8'h40, 8'h5C},
    {1'b0, 8'hFF, 8'h01}, {1'b0, 8'h00, 8'hEE}};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic peek(output logic [7:0] s);
    host_ofs = 4'd4; #1; s = host_rdata;
  endtask

  task automatic hw(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); host_ofs = o; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] o, output logic [7:0] v);
    @(negedge clk); host_ofs = o; host_rd = 1'b1; #1; v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_ibf();
    logic [7:0] s;
    do begin @(negedge clk); peek(s); end while (s[1]);
  endtask

  task automatic wait_obf();
    logic [7:0] s;
    do begin @(negedge clk); peek(s); end while (!s[0]);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    wait_ibf(); hw(4'd4, 8'h81);
    wait_ibf(); hw(4'd0, a);
    wait_ibf(); hw(4'd0, d);
    wait_ibf();
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
    wait_ibf(); hw(4'd4, 8'h80);
    wait_ibf(); hw(4'd0, a);
    wait_obf(); hr(4'd0, v);
  endtask

  initial begin
    logic [7:0] v, s;
    int n, w0;
    foreach (mem[i]) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    peek(s);   check("R1 status after reset", s, 8'h00);
    host_ofs = 4'd0; #1; check("R1 data after reset", host_rdata, 8'h00);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][16]) reg_write(VEC[i][15:8], VEC[i][7:0]);
      else begin
        reg_read(VEC[i][15:8], v);
        check("R6 read back (R5 write)", v, VEC[i][7:0]);
      end
    end

    // R3: IBF high for exactly N cycles, R4 command flag
    wait_ibf(); hw(4'd4, 8'h83);
    peek(s); check("R4 cmd flag after command", {7'd0, s[3]}, 8'd1);
    n = 0;
    while (s[1]) begin n++; @(negedge clk); peek(s); end
    check("R3 ibf window", 8'(n), 8'(N));
    wait_ibf(); hw(4'd0, 8'h77);
    peek(s); check("R4 cmd flag after data byte", {7'd0, s[3]}, 8'd0);
    wait_ibf(); peek(s);
    check("R11 stray data byte no obf", s, 8'h00);

    // R8 burst
    wait_ibf(); hw(4'd4, 8'h82); wait_ibf(); peek(s);
    check("R8 burst set / R2 layout", s, 8'h18);
    wait_ibf(); hw(4'd4, 8'h83); wait_ibf(); peek(s);
    check("R8 burst cleared", s & 8'h10, 8'h00);

    // R9 query, R7 clears
    wait_ibf(); hw(4'd4, 8'h84); wait_ibf(); peek(s);
    check("R9 query sets obf", s & 8'h01, 8'h01);
    hr(4'd4, s); peek(s);
    check("R7 status read keeps obf", s & 8'h01, 8'h01);
    hr(4'd0, v); check("R9 query data", v, 8'h00);
    peek(s); check("R7 data read clears obf", s & 8'h01, 8'h00);

    // R10 abort: write sequence interrupted by a read command
    w0 = wr_count;
    wait_ibf(); hw(4'd4, 8'h81);
    wait_ibf(); hw(4'd0, 8'h30);
    wait_ibf(); hw(4'd4, 8'h80);
    wait_ibf(); hw(4'd0, 8'h40);
    wait_obf(); hr(4'd0, v);
    check("R10 restarted read", v, 8'h5C);
    check("R10 no write on abort", 8'(wr_count - w0), 8'd0);
    reg_read(8'h30, v); check("R10 target untouched", v, 8'h11);

    // R11 unknown command
    w0 = wr_count;
    wait_ibf(); hw(4'd4, 8'h85); wait_ibf(); hw(4'd0, 8'h30);
    wait_ibf(); peek(s);
    check("R11 unknown cmd no obf", s & 8'h01, 8'h00);
    check("R11 unknown cmd no write", 8'(wr_count - w0), 8'd0);

    // R3 dropped write while busy
    wait_ibf(); hw(4'd4, 8'h81); hw(4'd4, 8'h82);
    wait_ibf(); peek(s);
    check("R3 dropped write burst stays clear", s & 8'h10, 8'h00);
    wait_ibf(); hw(4'd4, 8'h83); wait_ibf();

    // R12 other offsets
    hw(4'd8, 8'h82); peek(s);
    check("R12 offset 8 write ignored", s, 8'h08);
    hr(4'd8, v); check("R12 offset 8 reads zero", v, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule